// File: doc/BRIEF.md
# PHY Management Frame Responder

This block plays the role of the management slave of a physical-layer transceiver. Software drives a bit-banged serial management bus by writing a control register. Each write presents three bits to the block: a serial clock, a host data-out bit and a direction bit. The block returns one data-in bit, which software reads back. A frame advances only when the clock bit rises. The block sees that rise by comparing each written clock value with the one written before it.

The block holds 32 PHY addresses, each with 32 registers of 16 bits. A frame opens with a zero-then-one delimiter and a two-bit opcode. Then come the PHY and register addresses, a turnaround and sixteen data bits. A read frame shifts the addressed register out on the data-in bit, most significant bit first. A write frame collects sixteen bits and stores them in the addressed register. After the data phase the block pads the frame to a fixed length. It then waits for the next delimiter. Out of reset, PHY 0 register 1 reports a linked, fully negotiated, full-duplex link.

Top module: `mgmt_frame_responder`

## Requirements
- R1: After reset `mdiOut` is 0. Every register is 0 except PHY 0 register 1, which reads 0x502C. That value is bit 14 (100 Mb/s full duplex), bit 12 (10 Mb/s full duplex), bit 5 (negotiation complete), bit 3 (negotiation able) and bit 2 (link up).
- R2: A bit is taken only on a write (`wrEn`=1) with `wrClk`=1 whose previous write carried `wrClk`=0. Cycles without `wrEn`, and writes that do not raise the clock, change neither the frame position nor `mdiOut`.
- R3: A frame starts on a taken 0 followed later by a taken 1, both with `wrDir`=0. Ones before the 0 are ignored, and extra zeros before the 1 are allowed. A taken 1 with `wrDir`=1 while waiting for the 1 abandons the delimiter.
- R4: The two opcode bits arrive first bit high. 2'b10 is a read and 2'b01 is a write. Codes 00 and 11 consume the ten address bits, abort on the next bit, drive nothing and store nothing.
- R5: Five PHY address bits, then five register address bits, are taken MSB first.
- R6: In a read, the single turnaround bit returns 0. The sixteen data bits of the addressed register then appear on `mdiOut` MSB first, one per taken bit. A bit is driven only if that bit's write has `wrDir`=1, and the data bits advance even when it is 0.
- R7: After every taken bit that is not a driven read data bit, `mdiOut` is 0. Between taken bits `mdiOut` holds its value.
- R8: In a write, two turnaround bits are consumed and sixteen data bits are taken MSB first. The word is stored when the last data bit is taken.
- R9: A frame spans 31 taken bits from the first opcode bit. That leaves 2 idle bits after a read and 1 after a write, and the next taken bit is again a delimiter candidate.
- R10: Each of the 1024 registers, including PHY 0 register 1, is written and read independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrClk | input | 1 | Management clock bit of the written value |
| wrData | input | 1 | Host data-out bit of the written value |
| wrDir | input | 1 | Direction bit: 1 asks the block to drive |
| mdiOut | output | 1 | Data-in bit returned to the host |

## Verification
On every cycle, the assertions check that `mdiOut` and the datapath strobes move only on a taken clock rise. They check that a taken bit with the direction low always leaves `mdiOut` at 0, and that at most one datapath operation happens per bit. Only the bench scenarios can show the frame-level behaviour. That covers the delimiter, opcode-abort and idle-length boundaries, the values that read frames return after a sweep of writes across the register space, and the reset contents of the status register.

// File: rtl/mgmt_resp_pkg.sv
package mgmt_resp_pkg;

  typedef enum logic [2:0] {
    PH_HUNT,
    PH_START,
    PH_OPCODE,
    PH_ADDR,
    PH_TURN,
    PH_DATA,
    PH_IDLE
  } phaseT;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic sample;     // a clock rise was taken this cycle
    logic clrAddr;    // new frame: clear address shifters
    logic shiftPhy;   // shift data-out into PHY address
    logic shiftReg;   // shift data-out into register address
    logic loadRd;     // load addressed word for a read
    logic shiftData;  // shift the data register
    logic driveRd;    // present data MSB on data-in
    logic commit;     // store collected write word
  } strobeT;

endpackage

// File: rtl/mgmt_resp_ctrl.sv
module mgmt_resp_ctrl
  import mgmt_resp_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrEn,
  input  logic   wrClk,
  input  logic   wrData,
  input  logic   wrDir,
  output strobeT strb
);

  // Bit positions counted from the first opcode bit (position 0)
  localparam int PHY_LAST  = 1 + PHY_AW;
  localparam int ADDR_LAST = PHY_LAST + REG_AW;
  localparam int WR_TURN   = ADDR_LAST + 2;
  localparam int RD_LAST   = ADDR_LAST + 1 + DATA_W;
  localparam int WR_LAST   = ADDR_LAST + 2 + DATA_W;
  localparam int FRAME_END = WR_LAST + 2;
  localparam int CNT_W     = $clog2(FRAME_END + 1);

  logic              prevClk;
  logic              edgeSeen;
  phaseT             state, stateNxt;
  logic [CNT_W-1:0]  bitCnt, cntNxt;
  logic [1:0]        opc, opcNxt;

  assign edgeSeen = wrEn & wrClk & ~prevClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      state   <= PH_HUNT;
      bitCnt  <= '0;
      opc     <= '0;
    end else begin
      if (wrEn) prevClk <= wrClk;
      state  <= stateNxt;
      bitCnt <= cntNxt;
      opc    <= opcNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    opcNxt   = opc;
    strb     = '0;
    if (edgeSeen) begin
      strb.sample = 1'b1;
      unique case (state)
        PH_HUNT: begin
          if (!wrData && !wrDir) begin
            stateNxt     = PH_START;
            opcNxt       = '0;
            strb.clrAddr = 1'b1;
          end
        end
        PH_START: begin
          if (wrData) begin
            if (wrDir) stateNxt = PH_HUNT;
            else begin
              stateNxt = PH_OPCODE;
              cntNxt   = '0;
            end
          end
        end
        PH_OPCODE: begin
          cntNxt = bitCnt + 1'b1;
          if (bitCnt == '0) opcNxt = {wrData, 1'b0};
          else begin
            opcNxt   = {opc[1], wrData};
            stateNxt = PH_ADDR;
          end
        end
        PH_ADDR: begin
          cntNxt = bitCnt + 1'b1;
          if (bitCnt <= CNT_W'(PHY_LAST)) strb.shiftPhy = 1'b1;
          else                            strb.shiftReg = 1'b1;
          if (bitCnt == CNT_W'(ADDR_LAST)) stateNxt = PH_TURN;
        end
        PH_TURN: begin
          cntNxt = bitCnt + 1'b1;
          if (opc == OPC_READ) begin
            strb.loadRd = 1'b1;
            stateNxt    = PH_DATA;
          end else if (opc == OPC_WRITE) begin
            if (bitCnt == CNT_W'(WR_TURN)) stateNxt = PH_DATA;
          end else begin
            stateNxt = PH_HUNT;
          end
        end
        PH_DATA: begin
          cntNxt         = bitCnt + 1'b1;
          strb.shiftData = 1'b1;
          if (opc == OPC_READ) begin
            strb.driveRd = wrDir;
            if (bitCnt == CNT_W'(RD_LAST)) stateNxt = PH_IDLE;
          end else if (bitCnt == CNT_W'(WR_LAST)) begin
            strb.commit = 1'b1;
            stateNxt    = PH_IDLE;
          end
        end
        PH_IDLE: begin
          cntNxt = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(FRAME_END - 1)) stateNxt = PH_HUNT;
        end
        default: stateNxt = PH_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/mgmt_resp_datapath.sv
module mgmt_resp_datapath
  import mgmt_resp_pkg::*;
#(
  parameter int                PHY_AW     = 5,
  parameter int                REG_AW     = 5,
  parameter int                DATA_W     = 16,
  parameter int                STATUS_IDX = 1,
  parameter logic [DATA_W-1:0] STATUS_RST = 16'h502C
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrData,
  input  strobeT strb,
  output logic   mdiOut
);

  localparam int NPHY = 1 << PHY_AW;
  localparam int NREG = 1 << REG_AW;

  logic [PHY_AW-1:0] phyAddr;
  logic [REG_AW-1:0] regAddr;
  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-1:0] regFile [NPHY][NREG];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] wrWord;

  assign rdWord = regFile[phyAddr][regAddr];
  assign wrWord = {dataSh[DATA_W-2:0], wrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyAddr <= '0;
      regAddr <= '0;
      dataSh  <= '0;
      mdiOut  <= 1'b0;
    end else begin
      if (strb.clrAddr) begin
        phyAddr <= '0;
        regAddr <= '0;
      end
      if (strb.shiftPhy) phyAddr <= {phyAddr[PHY_AW-2:0], wrData};
      if (strb.shiftReg) regAddr <= {regAddr[REG_AW-2:0], wrData};
      if (strb.loadRd)         dataSh <= rdWord;
      else if (strb.shiftData) dataSh <= wrWord;
      if (strb.sample) mdiOut <= strb.driveRd ? dataSh[DATA_W-1] : 1'b0;
    end
  end

  for (genvar p = 0; p < NPHY; p++) begin : gPhy
    for (genvar r = 0; r < NREG; r++) begin : gReg
      localparam logic [DATA_W-1:0] RST_VAL =
        (p == 0 && r == STATUS_IDX) ? STATUS_RST : '0;
      always_ff @(posedge clk) begin
        if (!rstN) regFile[p][r] <= RST_VAL;
        else if (strb.commit && phyAddr == PHY_AW'(p) && regAddr == REG_AW'(r))
          regFile[p][r] <= wrWord;
      end
    end
  end

endmodule

// File: rtl/mgmt_frame_responder.sv
module mgmt_frame_responder
  import mgmt_resp_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrClk,
  input  logic wrData,
  input  logic wrDir,
  output logic mdiOut
);

  strobeT strb;

  mgmt_resp_ctrl #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClk(wrClk),
    .wrData(wrData), .wrDir(wrDir), .strb(strb)
  );

  mgmt_resp_datapath #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb), .mdiOut(mdiOut)
  );

endmodule

// File: rtl/mgmt_frame_responder_chk.sv
module mgmt_frame_responder_chk
  import mgmt_resp_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   wrEn,
  input logic   wrClk,
  input logic   wrDir,
  input logic   mdiOut,
  input strobeT strb
);

  logic seenClk;
  logic riseTaken;

  always_ff @(posedge clk) begin
    if (!rstN)     seenClk <= 1'b0;
    else if (wrEn) seenClk <= wrClk;
  end

  assign riseTaken = wrEn & wrClk & ~seenClk;

  a_r2_hold_without_rise: assert property (@(posedge clk) disable iff (!rstN)
    !riseTaken |=> $stable(mdiOut));

  a_r7_undriven_low: assert property (@(posedge clk) disable iff (!rstN)
    (riseTaken && !wrDir) |=> !mdiOut);

  a_r2_strobes_need_rise: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAddr || strb.shiftPhy || strb.shiftReg || strb.loadRd ||
     strb.shiftData || strb.commit) |-> riseTaken);

  a_r5_one_datapath_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrAddr, strb.shiftPhy, strb.shiftReg, strb.loadRd, strb.shiftData}));

  a_r6_drive_needs_dir: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveRd |-> (wrDir && strb.shiftData && !strb.commit));

  a_r8_commit_in_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (strb.shiftData && !strb.driveRd));

endmodule

bind mgmt_frame_responder mgmt_frame_responder_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClk(wrClk),
  .wrDir(wrDir), .mdiOut(mdiOut), .strb(strb)
);

// File: tb/mgmt_frame_responder_test.sv
`timescale 1ns/1ps
module mgmt_frame_responder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrClk = 1'b0, wrData = 1'b0, wrDir = 1'b0;
  logic mdiOut;
  int   vecs = 0, errs = 0;
  bit   noisy = 1'b0;

  always #2.5 clk = ~clk;

  mgmt_frame_responder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClk(wrClk),
    .wrData(wrData), .wrDir(wrDir), .mdiOut(mdiOut)
  );

  function automatic logic [15:0] pat(input int p, input int r);
    return 16'((p * 16'h0851) ^ (r * 16'h01F3) ^ 16'hA5C3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic d, input logic dr);
    @(negedge clk);
    wrEn = 1'b1; wrClk = c; wrData = d; wrDir = dr;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One taken bit; got = data-in after it
  task automatic tick(input logic d, input logic dr, output logic got);
    put(1'b0, d, dr);
    if (noisy) begin
      @(negedge clk); wrClk = 1'b1;   // clock toggles without a write
    end
    put(1'b1, d, dr);
    got = mdiOut;
    if (noisy) begin
      put(1'b1, ~d, dr);              // clock held high: no rise
      if (mdiOut !== got) chk("R2 hold", mdiOut, got);
    end
  endtask

  task automatic sendBits(input int val, input int n, input logic dr);
    logic g;
    for (int i = n - 1; i >= 0; i--) tick(val[i], dr, g);
  endtask

  task automatic readFrame(input int p, input int r, input logic rdDir,
                           output logic [15:0] val, output logic ta);
    logic g;
    sendBits(2'b01, 2, 1'b0);
    sendBits(2'b10, 2, 1'b0);
    sendBits(p, 5, 1'b0);
    sendBits(r, 5, 1'b0);
    tick(1'b1, 1'b1, ta);
    val = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b1, rdDir, g);
      val = {val[14:0], g};
    end
    sendBits(2'b11, 2, 1'b0);
  endtask

  task automatic writeFrame(input int p, input int r, input logic [15:0] v);
    sendBits(2'b01, 2, 1'b0);
    sendBits(2'b01, 2, 1'b0);
    sendBits(p, 5, 1'b0);
    sendBits(r, 5, 1'b0);
    sendBits(2'b10, 2, 1'b0);
    sendBits(int'(v), 16, 1'b0);
    sendBits(1, 1, 1'b0);
  endtask

  task automatic expectRead(input string tag, input int p, input int r,
                            input logic [15:0] exp);
    logic [15:0] v;
    logic ta;
    readFrame(p, r, 1'b1, v, ta);
    chk(tag, int'(v), int'(exp));
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic ta, g;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 mdiOut after reset", mdiOut, 0);

    // R1: reset contents
    readFrame(0, 1, 1'b1, v, ta);
    chk("R1 status reset", v, 16'h502C);
    chk("R6 read turnaround", ta, 0);
    expectRead("R1 zero reg", 0, 0, 16'h0000);
    expectRead("R1 zero other phy", 31, 1, 16'h0000);

    // R5 R8 R9 R10: write sweep then read sweep, frames back to back
    for (int p = 0; p < 32; p += 3)
      for (int r = 0; r < 32; r += 5) writeFrame(p, r, pat(p, r));
    for (int p = 0; p < 32; p += 3)
      for (int r = 0; r < 32; r += 5) begin
        readFrame(p, r, 1'b1, v, ta);
        chk("R5 R8 sweep readback", v, pat(p, r));
        chk("R6 turnaround zero", ta, 0);
        tick(1'b1, 1'b0, g);
        chk("R7 idle data-in low", g, 0);
        expectRead("R10 neighbour untouched", p + 1 < 32 ? p + 1 : 1, r, 16'h0000);
      end
    expectRead("R10 status kept", 0, 1, 16'h502C);

    // R2: spurious writes and clock toggles without writes
    noisy = 1'b1;
    expectRead("R2 noisy read", 3, 5, pat(3, 5));
    noisy = 1'b0;

    // R3: preamble of ones, extra zeros, then a delimiter abort by direction
    sendBits(32'hFFFFF, 20, 1'b0);
    sendBits(0, 3, 1'b0);
    expectRead("R3 preamble", 6, 10, pat(6, 10));
    tick(1'b0, 1'b0, g);
    tick(1'b1, 1'b1, g);
    expectRead("R3 direction abort", 9, 15, pat(9, 15));

    // R4: opcode 11 aborts after the address bits
    sendBits(2'b01, 2, 1'b0);
    sendBits(2'b11, 2, 1'b0);
    begin
      int seen = 0;
      for (int i = 0; i < 11; i++) begin
        tick(1'b1, 1'b1, g);
        seen += int'(g);
      end
      chk("R4 R7 no drive after bad opcode", seen, 0);
    end
    expectRead("R4 after opcode 11", 12, 20, pat(12, 20));

    // R4: opcode 00 carrying write-shaped bits stores nothing
    sendBits(2'b01, 2, 1'b0);
    sendBits(2'b00, 2, 1'b0);
    sendBits(2, 5, 1'b0);
    sendBits(2, 5, 1'b0);
    sendBits(2'b11, 2, 1'b0);
    sendBits(32'hFFFF, 16, 1'b0);
    expectRead("R4 opcode 00 no store", 2, 2, 16'h0000);

    // R6: direction low during read data drives nothing, frame still ends
    readFrame(3, 0, 1'b0, v, ta);
    chk("R6 undriven read", v, 16'h0000);
    expectRead("R9 next frame after undriven read", 3, 0, pat(3, 0));

    // R8 R10: boundary values, status register writable
    writeFrame(0, 1, 16'h1234);
    expectRead("R10 status write", 0, 1, 16'h1234);
    writeFrame(31, 31, 16'hFFFF);
    expectRead("R8 all ones", 31, 31, 16'hFFFF);
    writeFrame(31, 31, 16'h0001);
    expectRead("R8 lsb only", 31, 31, 16'h0001);
    writeFrame(31, 30, 16'h8000);
    expectRead("R9 write then read", 31, 30, 16'h8000);
    expectRead("R10 other reg kept", 31, 31, 16'h0001);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule